// File: doc/BRIEF.md
# Sigma-Delta Converter Configuration Port

This block is the peripheral side of a SPI mode 0 link for a single-channel sigma-delta converter. It sits beside the conversion engine and takes each new 24-bit result, together with a valid strobe, into a holding register. The host reaches a small register space through a one-byte command. Bit 6 of that byte selects read, and the low six bits give the address. A write command is followed by one data byte. A read command is followed by the bytes the register holds, most significant first.

The host can also switch the port into streaming. In streaming, every chip-select frame shifts out the held result straight away, with no command byte in front. A read of the data address issued as the first byte of a streaming frame returns the port to command mode. A two-write handshake on a two-bit field returns every register to its power-up state. The conversion-mode register chooses which strobes reach the holding register. Each strobe that is taken raises a one-cycle ready pulse.

The SPI pins are sampled with the system clock, so SCLK must run well below the clock rate: each SCLK level must last at least two clock cycles.

Top module: `spi_cfg_port`

## Requirements
- R1: The first byte of a command frame decodes as bit 6 = read and bits 5:0 = address; bit 7 is ignored. Unmapped addresses (all except 0x0A, 0x14, 0x18, 0x2C) read as 0x00, and writes to them change nothing. The reset-field address 0x1D is write-only and reads 0x00.
- R2: A write frame is the command byte with bit 6 clear followed by one data byte. The data byte is committed when its eighth bit is sampled, and any further bytes in that frame are ignored.
- R3: Read data follows the command byte MSB first. Address 0x2C returns the 24-bit result as three bytes; every other address returns one byte. MISO changes only while SCLK is low and reads 0 outside a frame.
- R4: Address 0x0A holds an 8-bit scratch value that reads back exactly what was last written.
- R5: Address 0x18 bits 2:0 hold the conversion mode and bits 7:3 read 0. Codes 0 and 3 take every strobe. Codes 1 and 2 take only the first strobe after that code is written, then hold the result. Codes 4 to 7 take no strobe.
- R6: `drdy_o` is high for exactly the one cycle after a strobe is taken, and never otherwise.
- R7: Writing a byte with bit 0 set to address 0x14 enables streaming from the next frame on. Register 0x14 reads back bit 0 as the streaming state. In streaming, MISO carries the three result bytes MSB first from the first SCLK of the frame, and MOSI is never decoded as a write.
- R8: In a streaming frame, a first MOSI byte whose bits 6:0 equal 0x6C (read of 0x2C) ends streaming. The frame still returns the result, and later frames are decoded as commands.
- R9: The result returned in a frame is the value held in the cycle before chip select falls. A strobe in the same cycle as that falling edge, or later, shows only in later frames.
- R10: Two back-to-back writes to address 0x1D, bits 1:0 = 2'b11 and then 2'b10, return scratch, mode, streaming and the held result to zero. Any other write between them, to any address or with any other value, cancels the sequence.
- R11: Chip select rising in the middle of a byte aborts the frame with nothing committed, and the next frame starts cleanly at bit 0.
- R12: After `rst_ni` the port is in command mode, mode 0, with scratch and result at zero and `drdy_o` low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock; SPI pins are sampled on its rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sclk_i | input | 1 | SPI serial clock, idle low |
| csn_i | input | 1 | SPI chip select, active low |
| mosi_i | input | 1 | Serial data from the host |
| miso_o | output | 1 | Serial data to the host |
| sample_valid_i | input | 1 | One-cycle strobe: a new conversion result is present |
| sample_data_i | input | 24 | Conversion result |
| drdy_o | output | 1 | One-cycle pulse after a result is taken |

## Verification
A new result can arrive in the same cycle that chip select falls and the frame takes its snapshot. The bench raises the strobe on the same clock as the chip-select edge. It then requires the frame to return the older value and the following frame to return the new one. A strobe can also land while a mode write is being committed. The sweep over all eight mode codes sends two strobes after each mode write and compares both the ready pulses and the read-back result with a model kept in the bench.

// File: rtl/spi_cfg_pkg.sv
package spi_cfg_pkg;
  localparam int unsigned ADDR_W = 6;
  localparam int unsigned BYTE_W = 8;

  localparam logic [ADDR_W-1:0] ADR_SCRATCH = 6'h0A;
  localparam logic [ADDR_W-1:0] ADR_IFACE   = 6'h14;
  localparam logic [ADDR_W-1:0] ADR_CONV    = 6'h18;
  localparam logic [ADDR_W-1:0] ADR_RST     = 6'h1D;
  localparam logic [ADDR_W-1:0] ADR_DATA    = 6'h2C;

  localparam logic [1:0] RST_ARM  = 2'b11;
  localparam logic [1:0] RST_FIRE = 2'b10;

  typedef enum logic [2:0] {
    CM_CONT     = 3'd0,
    CM_ONESHOT  = 3'd1,
    CM_SINGLE   = 3'd2,
    CM_PERIODIC = 3'd3,
    CM_STANDBY  = 3'd4
  } conv_mode_e;
endpackage

// File: rtl/spi_cfg_shifter.sv
module spi_cfg_shifter #(
  parameter int unsigned BYTE_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sclk_i,
  input  logic              csn_i,
  input  logic              mosi_i,
  input  logic [BYTE_W-1:0] tx_next_i,
  output logic              miso_o,
  output logic              frame_start_o,
  output logic              byte_done_o,
  output logic [BYTE_W-1:0] rx_byte_o
);
  localparam int unsigned CNT_W = $clog2(BYTE_W);

  logic              sclk_q, csn_q, start_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [BYTE_W-1:0] rx_q, tx_q;
  logic              rise, fall;

  assign rise          = sclk_i & ~sclk_q & ~csn_i;
  assign fall          = ~sclk_i & sclk_q & ~csn_i;
  assign frame_start_o = csn_q & ~csn_i;
  assign byte_done_o   = rise && (cnt_q == CNT_W'(BYTE_W-1));
  assign rx_byte_o     = {rx_q[BYTE_W-2:0], mosi_i};
  assign miso_o        = tx_q[BYTE_W-1];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sclk_q  <= 1'b0;
      csn_q   <= 1'b1;
      start_q <= 1'b0;
      cnt_q   <= '0;
      rx_q    <= '0;
      tx_q    <= '0;
    end else begin
      sclk_q  <= sclk_i;
      csn_q   <= csn_i;
      start_q <= frame_start_o;
      if (csn_i) begin
        cnt_q <= '0;
        tx_q  <= '0;
      end else begin
        if (rise) begin
          rx_q  <= rx_byte_o;
          cnt_q <= (cnt_q == CNT_W'(BYTE_W-1)) ? '0 : cnt_q + 1'b1;
        end
        // first byte loads one cycle after the frame snapshot; later bytes on the boundary fall
        if (start_q)
          tx_q <= tx_next_i;
        else if (fall)
          tx_q <= (cnt_q == '0) ? tx_next_i : {tx_q[BYTE_W-2:0], 1'b0};
      end
    end
  end
endmodule

// File: rtl/spi_cfg_regs.sv
module spi_cfg_regs
  import spi_cfg_pkg::*;
#(
  parameter int unsigned SAMPLE_W = 24
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                wr_en_i,
  input  logic [ADDR_W-1:0]   wr_addr_i,
  input  logic [BYTE_W-1:0]   wr_data_i,
  input  logic [ADDR_W-1:0]   rd_addr_i,
  output logic [BYTE_W-1:0]   rd_data_o,
  input  logic                stream_exit_i,
  input  logic                sample_valid_i,
  input  logic [SAMPLE_W-1:0] sample_data_i,
  output logic [SAMPLE_W-1:0] sample_o,
  output logic                drdy_o,
  output logic                stream_o,
  output logic [2:0]          mode_o,
  output logic [BYTE_W-1:0]   scratch_o,
  output logic                soft_rst_o
);
  logic [BYTE_W-1:0]   scratch_q;
  conv_mode_e          mode_q;
  logic                stream_q, seq_arm_q, shot_arm_q, drdy_q;
  logic [SAMPLE_W-1:0] sample_q;
  logic                soft_rst, latch_every, latch_once, take, wr_once;

  always_comb begin
    soft_rst    = wr_en_i && (wr_addr_i == ADR_RST) && (wr_data_i[1:0] == RST_FIRE) && seq_arm_q;
    latch_every = (mode_q == CM_CONT) || (mode_q == CM_PERIODIC);
    latch_once  = (mode_q == CM_ONESHOT) || (mode_q == CM_SINGLE);
    take        = sample_valid_i && (latch_every || (latch_once && shot_arm_q));
    wr_once     = (wr_data_i[2:0] == CM_ONESHOT) || (wr_data_i[2:0] == CM_SINGLE);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      scratch_q  <= '0;
      mode_q     <= CM_CONT;
      stream_q   <= 1'b0;
      seq_arm_q  <= 1'b0;
      shot_arm_q <= 1'b0;
      drdy_q     <= 1'b0;
      sample_q   <= '0;
    end else if (soft_rst) begin
      scratch_q  <= '0;
      mode_q     <= CM_CONT;
      stream_q   <= 1'b0;
      seq_arm_q  <= 1'b0;
      shot_arm_q <= 1'b0;
      drdy_q     <= 1'b0;
      sample_q   <= '0;
    end else begin
      drdy_q <= take;
      if (take) begin
        sample_q <= sample_data_i;
        if (latch_once) shot_arm_q <= 1'b0;
      end
      if (stream_exit_i) stream_q <= 1'b0;
      if (wr_en_i) begin
        seq_arm_q <= (wr_addr_i == ADR_RST) && (wr_data_i[1:0] == RST_ARM);
        case (wr_addr_i)
          ADR_SCRATCH: scratch_q <= wr_data_i;
          ADR_IFACE:   stream_q  <= wr_data_i[0];
          ADR_CONV: begin
            mode_q     <= conv_mode_e'(wr_data_i[2:0]);
            shot_arm_q <= wr_once;
          end
          default: ;
        endcase
      end
    end
  end

  always_comb begin
    case (rd_addr_i)
      ADR_SCRATCH: rd_data_o = scratch_q;
      ADR_IFACE:   rd_data_o = {{(BYTE_W-1){1'b0}}, stream_q};
      ADR_CONV:    rd_data_o = {{(BYTE_W-3){1'b0}}, mode_q};
      default:     rd_data_o = '0;
    endcase
  end

  assign sample_o   = sample_q;
  assign drdy_o     = drdy_q;
  assign stream_o   = stream_q;
  assign mode_o     = mode_q;
  assign scratch_o  = scratch_q;
  assign soft_rst_o = soft_rst;
endmodule

// File: rtl/spi_cfg_port.sv
module spi_cfg_port
  import spi_cfg_pkg::*;
#(
  parameter int unsigned DATA_BYTES = 3
) (
  input  logic                         clk_i,
  input  logic                         rst_ni,
  input  logic                         sclk_i,
  input  logic                         csn_i,
  input  logic                         mosi_i,
  output logic                         miso_o,
  input  logic                         sample_valid_i,
  input  logic [DATA_BYTES*BYTE_W-1:0] sample_data_i,
  output logic                         drdy_o
);
  localparam int unsigned SAMPLE_W = DATA_BYTES * BYTE_W;
  localparam int unsigned IDX_MAX  = DATA_BYTES + 1;
  localparam int unsigned IDX_W    = $clog2(IDX_MAX + 1);

  logic                frame_start, byte_done;
  logic [BYTE_W-1:0]   rx_byte, tx_next, rd_data, scratch;
  logic [IDX_W-1:0]    idx_q, sel;
  logic                sel_ok;
  logic                is_stream_q, is_read_q;
  logic [ADDR_W-1:0]   addr_q;
  logic [SAMPLE_W-1:0] snap_q, sample;
  logic                stream, soft_rst, wr_en, stream_exit;
  logic [2:0]          mode;

  spi_cfg_shifter #(.BYTE_W(BYTE_W)) u_shift (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .sclk_i       (sclk_i),
    .csn_i        (csn_i),
    .mosi_i       (mosi_i),
    .tx_next_i    (tx_next),
    .miso_o       (miso_o),
    .frame_start_o(frame_start),
    .byte_done_o  (byte_done),
    .rx_byte_o    (rx_byte)
  );

  assign wr_en       = byte_done && (idx_q == IDX_W'(1)) && !is_stream_q && !is_read_q;
  assign stream_exit = byte_done && (idx_q == '0) && is_stream_q &&
                       (rx_byte[ADDR_W:0] == {1'b1, ADR_DATA});

  spi_cfg_regs #(.SAMPLE_W(SAMPLE_W)) u_regs (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .wr_en_i       (wr_en),
    .wr_addr_i     (addr_q),
    .wr_data_i     (rx_byte),
    .rd_addr_i     (addr_q),
    .rd_data_o     (rd_data),
    .stream_exit_i (stream_exit),
    .sample_valid_i(sample_valid_i),
    .sample_data_i (sample_data_i),
    .sample_o      (sample),
    .drdy_o        (drdy_o),
    .stream_o      (stream),
    .mode_o        (mode),
    .scratch_o     (scratch),
    .soft_rst_o    (soft_rst)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      idx_q       <= '0;
      is_stream_q <= 1'b0;
      is_read_q   <= 1'b0;
      addr_q      <= '0;
      snap_q      <= '0;
    end else if (frame_start) begin
      idx_q       <= '0;
      is_stream_q <= stream;
      is_read_q   <= 1'b0;
      snap_q      <= sample;
    end else if (byte_done) begin
      if (idx_q != IDX_W'(IDX_MAX)) idx_q <= idx_q + 1'b1;
      if (idx_q == '0 && !is_stream_q) begin
        is_read_q <= rx_byte[ADDR_W];
        addr_q    <= rx_byte[ADDR_W-1:0];
      end
    end
  end

  // idx_q counts finished bytes; the byte loaded next is picked from it
  always_comb begin
    tx_next = '0;
    sel     = '0;
    sel_ok  = 1'b0;
    if (is_stream_q) begin
      sel    = idx_q;
      sel_ok = 1'b1;
    end else if (is_read_q && idx_q != '0) begin
      if (addr_q == ADR_DATA) begin
        sel    = idx_q - 1'b1;
        sel_ok = 1'b1;
      end else if (idx_q == IDX_W'(1)) begin
        tx_next = rd_data;
      end
    end
    if (sel_ok) begin
      for (int b = 0; b < DATA_BYTES; b++) begin
        if (sel == IDX_W'(b)) tx_next = snap_q[SAMPLE_W-1-BYTE_W*b -: BYTE_W];
      end
    end
  end
endmodule

// File: rtl/spi_cfg_port_chk.sv
module spi_cfg_port_chk
  import spi_cfg_pkg::*;
(
  input logic              clk_i,
  input logic              rst_ni,
  input logic              sclk_i,
  input logic              csn_i,
  input logic              miso_o,
  input logic              sample_valid_i,
  input logic              drdy_o,
  input logic [2:0]        mode_i,
  input logic              byte_done_i,
  input logic [BYTE_W-1:0] rx_byte_i,
  input logic              is_stream_i,
  input logic              stream_i,
  input logic [BYTE_W-1:0] scratch_i,
  input logic              soft_rst_i
);
  a_r6_drdy_after_strobe: assert property (@(posedge clk_i) disable iff (!rst_ni)
    drdy_o |-> $past(sample_valid_i));

  a_r3_miso_still_high_sclk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sclk_i && $past(sclk_i) && !csn_i && !$past(csn_i)) |-> $stable(miso_o));

  // covers R11 as well: nothing is committed outside a completed byte
  a_r2_scratch_on_byte: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$past(byte_done_i) |-> $stable(scratch_i));

  a_r8_stream_leave: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (byte_done_i && is_stream_i && rx_byte_i[ADDR_W:0] == {1'b1, ADR_DATA}) |=> !stream_i);

  a_r10_soft_reset_defaults: assert property (@(posedge clk_i) disable iff (!rst_ni)
    soft_rst_i |=> (scratch_i == '0 && !stream_i && mode_i == 3'd0 && !drdy_o));
endmodule

bind spi_cfg_port spi_cfg_port_chk u_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .sclk_i        (sclk_i),
  .csn_i         (csn_i),
  .miso_o        (miso_o),
  .sample_valid_i(sample_valid_i),
  .drdy_o        (drdy_o),
  .mode_i        (mode),
  .byte_done_i   (byte_done),
  .rx_byte_i     (rx_byte),
  .is_stream_i   (is_stream_q),
  .stream_i      (stream),
  .scratch_i     (scratch),
  .soft_rst_i    (soft_rst)
);

// File: tb/spi_cfg_port_test.sv
module spi_cfg_port_test;
  localparam int HALF = 2;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        sclk = 1'b0, csn = 1'b1, mosi = 1'b0;
  logic        miso, drdy;
  logic        sv = 1'b0;
  logic [23:0] sd = '0;

  int n_chk = 0, n_bad = 0, cyc = 0;
  logic [23:0] model;

  always #5 clk = ~clk;

  spi_cfg_port uut (
    .clk_i(clk), .rst_ni(rst_ni), .sclk_i(sclk), .csn_i(csn), .mosi_i(mosi),
    .miso_o(miso), .sample_valid_i(sv), .sample_data_i(sd), .drdy_o(drdy)
  );

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 150000) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual %0d cycles expected below 150000", cyc);
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

  task automatic tick(); @(posedge clk); #1; endtask

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic xbyte(input logic [7:0] o, output logic [7:0] i);
    for (int b = 7; b >= 0; b--) begin
      mosi = o[b];
      repeat (HALF) tick();
      i[b] = miso;
      sclk = 1'b1;
      repeat (HALF) tick();
      sclk = 1'b0;
    end
  endtask

  task automatic frame(input logic [31:0] txw, input int n, input bit strobe,
                       input logic [23:0] val, output logic [31:0] rxw);
    logic [7:0] r;
    rxw = '0;
    csn = 1'b0;
    if (strobe) begin sv = 1'b1; sd = val; end
    tick();
    sv = 1'b0;
    tick(); tick();
    for (int k = 0; k < n; k++) begin
      xbyte(txw[31-8*k -: 8], r);
      rxw = {rxw[23:0], r};
    end
    tick(); tick();
    csn = 1'b1;
    repeat (3) tick();
  endtask

  task automatic wr(input logic [5:0] a, input logic [7:0] d);
    logic [31:0] x;
    frame({2'b00, a, d, 16'h0}, 2, 1'b0, '0, x);
  endtask

  task automatic rd1(input logic [7:0] cmd, output logic [7:0] d);
    logic [31:0] x;
    frame({cmd, 24'h0}, 2, 1'b0, '0, x);
    d = x[7:0];
  endtask

  task automatic rd3(input bit strobe, input logic [23:0] val, output logic [23:0] d);
    logic [31:0] x;
    frame({8'h6C, 24'h0}, 4, strobe, val, x);
    d = x[23:0];
  endtask

  task automatic push(input logic [23:0] d, output logic pulse);
    sd = d; sv = 1'b1;
    tick();
    sv = 1'b0;
    pulse = drdy;
    tick();
    check("R6 single-cycle drdy", {31'b0, drdy}, 32'h0);
  endtask

  initial begin
    logic [7:0]  b8;
    logic [23:0] b24;
    logic [31:0] x;
    logic        p;

    repeat (4) tick();
    rst_ni = 1'b1;
    repeat (3) tick();

    // R12 reset state
    check("R12 drdy low", {31'b0, drdy}, 32'h0);
    check("R3 miso idle", {31'b0, miso}, 32'h0);
    rd1(8'h4A, b8); check("R12 scratch zero", {24'b0, b8}, 32'h0);
    rd1(8'h58, b8); check("R12 mode zero", {24'b0, b8}, 32'h0);
    rd1(8'h54, b8); check("R12 not streaming", {24'b0, b8}, 32'h0);
    rd3(1'b0, '0, b24); check("R12 result zero", {8'b0, b24}, 32'h0);

    // R4 full scratch sweep
    for (int v = 0; v < 256; v++) begin
      wr(6'h0A, 8'(v));
      rd1(8'h4A, b8);
      check("R4 scratch readback", {24'b0, b8}, v);
    end

    // R1 bit 7 ignored, unmapped addresses
    wr(6'h0A, 8'h5C);
    rd1(8'hCA, b8); check("R1 bit7 ignored", {24'b0, b8}, 32'h5C);
    foreach (x[i]) if (i < 6) begin
      logic [5:0] a;
      a = (i == 0) ? 6'h00 : (i == 1) ? 6'h3F : (i == 2) ? 6'h2B :
          (i == 3) ? 6'h1D : (i == 4) ? 6'h0B : 6'h15;
      wr(a, 8'hA5);
      rd1({2'b01, a}, b8); check("R1 unmapped reads zero", {24'b0, b8}, 32'h0);
    end
    rd1(8'h4A, b8); check("R1 unmapped write ignored", {24'b0, b8}, 32'h5C);

    // R2 extra bytes after a write ignored
    frame({8'h0A, 8'h33, 8'h44, 8'h55}, 4, 1'b0, '0, x);
    rd1(8'h4A, b8); check("R2 extra bytes ignored", {24'b0, b8}, 32'h33);

    // R5/R6 sweep every mode code
    model = '0;
    for (int m = 0; m < 8; m++) begin
      logic every, once;
      logic [23:0] v1, v2;
      every = (m == 0) || (m == 3);
      once  = (m == 1) || (m == 2);
      v1 = 24'h100000 + 24'(m) * 24'h010101;
      v2 = 24'h800000 + 24'(m) * 24'h020202;
      wr(6'h18, 8'hF8 | 8'(m));
      rd1(8'h58, b8); check("R5 mode readback masked", {24'b0, b8}, m);
      push(v1, p); check("R6 first strobe pulse", {31'b0, p}, {31'b0, every | once});
      if (every | once) model = v1;
      push(v2, p); check("R6 second strobe pulse", {31'b0, p}, {31'b0, every});
      if (every) model = v2;
      rd3(1'b0, '0, b24); check("R5 held result", {8'b0, b24}, {8'b0, model});
    end
    // R5 re-arm of one-shot by rewriting the code
    wr(6'h18, 8'h01);
    push(24'hABCDEF, p); model = 24'hABCDEF;
    push(24'h111111, p);
    wr(6'h18, 8'h01);
    push(24'h222222, p); check("R5 re-armed pulse", {31'b0, p}, 32'h1);
    rd3(1'b0, '0, b24); check("R5 re-armed result", {8'b0, b24}, 32'h222222);
    wr(6'h18, 8'h00);

    // R9 strobe together with chip-select fall
    push(24'h0A0B0C, p);
    rd3(1'b1, 24'h0D0E0F, b24); check("R9 snapshot before strobe", {8'b0, b24}, 32'h0A0B0C);
    rd3(1'b0, '0, b24); check("R9 new value next frame", {8'b0, b24}, 32'h0D0E0F);

    // R7 streaming
    wr(6'h0A, 8'h77);
    wr(6'h14, 8'h01);
    frame(32'h0, 3, 1'b0, '0, x); check("R7 stream frame", {8'b0, x[23:0]}, 32'h0D0E0F);
    push(24'h123456, p);
    frame(32'h0, 3, 1'b0, '0, x); check("R7 stream new sample", {8'b0, x[23:0]}, 32'h123456);
    frame({8'h0A, 8'h99, 16'h0}, 3, 1'b0, '0, x); check("R7 stream ignores cmd", {8'b0, x[23:0]}, 32'h123456);
    // R8 exit
    frame({8'h6C, 24'h0}, 3, 1'b0, '0, x); check("R8 exit frame data", {8'b0, x[23:0]}, 32'h123456);
    rd1(8'h54, b8); check("R8 streaming off", {24'b0, b8}, 32'h0);
    rd1(8'h4A, b8); check("R7 scratch untouched", {24'b0, b8}, 32'h77);

    // R11 abort mid-byte
    csn = 1'b0; repeat (3) tick();
    xbyte(8'h0A, b8);
    for (int b = 7; b >= 4; b--) begin
      mosi = 1'b1; repeat (HALF) tick(); sclk = 1'b1; repeat (HALF) tick(); sclk = 1'b0;
    end
    tick(); csn = 1'b1; repeat (3) tick();
    rd1(8'h4A, b8); check("R11 abort no commit", {24'b0, b8}, 32'h77);
    wr(6'h0A, 8'h66);
    rd1(8'h4A, b8); check("R11 clean next frame", {24'b0, b8}, 32'h66);

    // R10 reset sequence
    wr(6'h1D, 8'h03); wr(6'h0A, 8'h11); wr(6'h1D, 8'h02);
    rd1(8'h4A, b8); check("R10 broken by other address", {24'b0, b8}, 32'h11);
    wr(6'h1D, 8'h03); wr(6'h1D, 8'h01); wr(6'h1D, 8'h02);
    rd1(8'h4A, b8); check("R10 broken by other value", {24'b0, b8}, 32'h11);
    wr(6'h18, 8'h03);
    wr(6'h1D, 8'h03); wr(6'h1D, 8'h03); wr(6'h1D, 8'h02);
    rd1(8'h4A, b8); check("R10 scratch cleared", {24'b0, b8}, 32'h0);
    rd1(8'h58, b8); check("R10 mode cleared", {24'b0, b8}, 32'h0);
    rd3(1'b0, '0, b24); check("R10 result cleared", {8'b0, b24}, 32'h0);
    rd1(8'h5D, b8); check("R1 reset field reads zero", {24'b0, b8}, 32'h0);

    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule